// File: doc/BRIEF.md
# Pulse Width Doubler

This block watches a single-bit input on every rising clock edge and produces an output pulse that lasts twice as many clock cycles as the input was seen high. It measures the input with one up/down counter. Every edge that samples the input high adds one to the counter. Every edge that samples the input low while the counter holds a nonzero value removes one. The output is the registered OR of the sampled input and a nonzero counter, so it follows the measured input length rather than a fixed stretch.

The block resolves time only to whole clock cycles. An input excursion that starts and ends between two rising edges is never seen, so the clock period must not exceed the shortest pulse to be handled. When a new pulse arrives while the output tail is still draining, the counter resumes counting up from whatever remains. The output then stays high without a break until the combined count has drained. The counter is W bits wide and stops at its maximum instead of wrapping. A sticky flag records that this limit was reached.

Top module: `pulse_width_doubler`

## Requirements
- R1: A low level on `rst_n` at a rising edge clears the counter, the output and the overflow flag; after release with the input low, the output stays low.
- R2: An isolated input pulse sampled high on N consecutive edges (counter zero beforehand) yields exactly 2N consecutive output-high cycles and a single output rise.
- R3: The output is high in the cycle that follows the first edge at which the input is sampled high, and low in the cycle before that edge.
- R4: A single-cycle input pulse (N = 1) yields an output pulse exactly two cycles long.
- R5: If the input rises again while the counter is nonzero, counting resumes from the remaining value; the output stays high through the gap and lasts 2 x (total sampled-high cycles) in one unbroken pulse.
- R6: With the counter at 2^W-1 and the input high, the counter holds at 2^W-1 and does not wrap; a pulse of M > 2^W-1 cycles gives an output of M + 2^W-1 cycles.
- R7: `ovf_o` rises on the edge after the input is sampled high with the counter at 2^W-1. It stays high until reset, and it stays low if that never happens.
- R8: The input is sampled only at rising edges; a high excursion that begins and ends between two edges has no effect on the output.
- R9: While the input is low and the counter is zero, the output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_i | input | 1 | Input pulse, sampled on each rising edge |
| pulse_o | output | 1 | Registered output pulse, twice the sampled input length |
| ovf_o | output | 1 | Sticky flag: the counter hit its ceiling while counting up |

## Verification
The bench targets the one-cycle pulse. A counter that compared with the wrong bound, or an output that was not ORed with the live input, would give one or three cycles there instead of two. It re-triggers during the tail to catch a design that restarts the count or drops the output for a cycle in the gap. It drives a pulse longer than the counter range to catch a counter that wraps to zero, which would cut the output short, and to catch a flag that is not sticky. A sub-cycle glitch and a reset issued in the middle of a tail expose a design that reacts outside clock edges or leaves a stale count behind.

// File: rtl/pwd_pkg.sv
// Package: shared types for the pulse width doubler.
// Assumes: nothing beyond IEEE 1800-2017.
package pwd_pkg;

    // Counter operation chosen each cycle from the sampled input.
    typedef enum logic [1:0] {
        TALLY_HOLD = 2'd0,
        TALLY_UP   = 2'd1,
        TALLY_DOWN = 2'd2
    } tally_op_e;

    // Picks the counter operation: count up while high, drain while low.
    function automatic tally_op_e pick_op(input logic level, input logic nonzero);
        if (level)
            return TALLY_UP;
        else if (nonzero)
            return TALLY_DOWN;
        else
            return TALLY_HOLD;
    endfunction

endpackage

// File: rtl/pwd_tally.sv
// Module: saturating up/down cycle counter.
// Does: counts up on TALLY_UP, down on TALLY_DOWN, holds otherwise.
// Assumes: TALLY_DOWN is only requested when the count is nonzero;
//          counting up at the ceiling holds the value and pulses sat_hit_o.
module pwd_tally #(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pwd_pkg::tally_op_e    op_i,
    output logic [W-1:0]          cnt_o,
    output logic                  nonzero_o,
    output logic                  sat_hit_o
);
    import pwd_pkg::*;

    localparam logic [W-1:0] CEIL = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic         at_ceil;

    // Flags derived from the present count.
    always_comb begin
        at_ceil   = (cnt_q == CEIL);
        nonzero_o = (cnt_q != '0);
        sat_hit_o = (op_i == TALLY_UP) && at_ceil;
    end

    // Count register with saturation at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else begin
            case (op_i)
                TALLY_UP:   if (!at_ceil) cnt_q <= cnt_q + ONE;
                TALLY_DOWN: cnt_q <= cnt_q - ONE;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pwd_sticky.sv
// Module: sticky flag.
// Does: goes high on the edge after set_i and stays high until reset.
// Assumes: synchronous active-low reset.
module pwd_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic flag_o
);
    logic flag_q;

    // Latch the event until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= flag_q | set_i;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/pwd_out_stage.sv
// Module: registered output driver.
// Does: registers (input level OR count nonzero).
// Assumes: nonzero_i reflects the count before the current edge.
module pwd_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic nonzero_i,
    output logic out_o
);
    logic out_q;

    // Output flop: high while the input is high or a tail remains.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else
            out_q <= level_i | nonzero_i;
    end

    assign out_o = out_q;

endmodule

// File: rtl/pulse_width_doubler.sv
// Module: clocked pulse width doubler (top).
// Does: stretches each input pulse to twice its sampled length, with the
//       output registered one cycle behind the input.
// Assumes: pulse_i is synchronous to clk; excursions between edges are unseen.
module pulse_width_doubler #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic pulse_o,
    output logic ovf_o
);
    import pwd_pkg::*;

    tally_op_e    op;
    logic [W-1:0] cnt_q;
    logic         nonzero;
    logic         sat_hit;

    // Decide the counter step for this cycle.
    always_comb op = pick_op(pulse_i, nonzero);

    pwd_tally #(.W(W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .cnt_o     (cnt_q),
        .nonzero_o (nonzero),
        .sat_hit_o (sat_hit)
    );

    pwd_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (pulse_i),
        .nonzero_i (nonzero),
        .out_o     (pulse_o)
    );

    pwd_sticky u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sat_hit),
        .flag_o (ovf_o)
    );

endmodule

// File: rtl/pulse_width_doubler_chk.sv
// Checker: temporal properties of the pulse width doubler, bound to the top.
module pulse_width_doubler_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pulse_i,
    input logic         pulse_o,
    input logic         ovf_o,
    input logic [W-1:0] cnt
);
    localparam logic [W-1:0] CEIL = {W{1'b1}};

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!pulse_o && !ovf_o && cnt == '0));

    p_rise_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> pulse_o);

    p_drain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_i && cnt != '0) |=> (pulse_o && cnt == $past(cnt) - 1'b1));

    p_resume_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i && cnt != CEIL) |=> (cnt == $past(cnt) + 1'b1));

    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i && cnt == CEIL) |=> (cnt == CEIL && ovf_o));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_i && cnt == '0) |=> !pulse_o);

endmodule

bind pulse_width_doubler pulse_width_doubler_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (pulse_i),
    .pulse_o (pulse_o),
    .ovf_o   (ovf_o),
    .cnt     (cnt_q)
);

// File: tb/pulse_width_doubler_tb.sv
module pulse_width_doubler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int CEIL       = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic pulse_i;
    logic pulse_o;
    logic ovf_o;

    int n_checks = 0;
    int n_fail   = 0;
    int hi_cnt   = 0;
    int rises    = 0;
    logic prev_o = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_width_doubler #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse_i),
        .pulse_o (pulse_o),
        .ovf_o   (ovf_o)
    );

    // Output monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (pulse_o) hi_cnt++;
        if (pulse_o && !prev_o) rises++;
        prev_o = pulse_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk);
        #1;
        hi_cnt = 0;
        rises  = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        pulse_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk(pulse_o == 1'b0, "R1 out after reset", int'(pulse_o), 0);
        chk(ovf_o == 1'b0, "R1 ovf after reset", int'(ovf_o), 0);
    endtask

    task automatic t_idle();
        clear_mon();
        repeat (20) @(negedge clk);
        chk(hi_cnt == 0, "R9 idle output", hi_cnt, 0);
    endtask

    // Isolated pulse of n sampled-high cycles.
    task automatic t_isolated(input int n, input string req);
        clear_mon();
        @(negedge clk);
        chk(pulse_o == 1'b0, "R3 low before first sample", int'(pulse_o), 0);
        pulse_i = 1'b1;
        @(negedge clk);
        chk(pulse_o == 1'b1, "R3 high after first sample", int'(pulse_o), 1);
        if (n > 1) repeat (n - 1) @(negedge clk);
        pulse_i = 1'b0;
        repeat (2*n + 4) @(negedge clk);
        chk(hi_cnt == 2*n, req, hi_cnt, 2*n);
        chk(rises == 1, {req, " single rise"}, rises, 1);
    endtask

    // Two pulses with a gap inside the first tail.
    task automatic t_overlap(input int a, input int gap, input int b);
        clear_mon();
        @(negedge clk);
        pulse_i = 1'b1;
        repeat (a) @(negedge clk);
        pulse_i = 1'b0;
        repeat (gap) @(negedge clk);
        pulse_i = 1'b1;
        repeat (b) @(negedge clk);
        pulse_i = 1'b0;
        repeat (2*(a+b) + 6) @(negedge clk);
        chk(hi_cnt == 2*(a+b), "R5 overlap length", hi_cnt, 2*(a+b));
        chk(rises == 1, "R5 output unbroken", rises, 1);
    endtask

    task automatic t_glitch();
        clear_mon();
        @(negedge clk);
        #1 pulse_i = 1'b1;
        #2 pulse_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(hi_cnt == 0, "R8 sub-cycle glitch ignored", hi_cnt, 0);
    endtask

    task automatic t_saturate(input int m);
        chk(ovf_o == 1'b0, "R7 flag low before saturation", int'(ovf_o), 0);
        clear_mon();
        @(negedge clk);
        pulse_i = 1'b1;
        repeat (m) @(negedge clk);
        pulse_i = 1'b0;
        repeat (CEIL + 6) @(negedge clk);
        chk(hi_cnt == m + CEIL, "R6 saturated length", hi_cnt, m + CEIL);
        chk(ovf_o == 1'b1, "R7 flag set on saturation", int'(ovf_o), 1);
        t_isolated(2, "R2 pulse after saturation");
        chk(ovf_o == 1'b1, "R7 flag sticky", int'(ovf_o), 1);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        pulse_i = 1'b1;
        repeat (5) @(negedge clk);
        pulse_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(pulse_o == 1'b0, "R1 out cleared mid tail", int'(pulse_o), 0);
        chk(ovf_o == 1'b0, "R1 ovf cleared", int'(ovf_o), 0);
        rst_n = 1'b1;
        clear_mon();
        repeat (12) @(negedge clk);
        chk(hi_cnt == 0, "R1 no stale tail", hi_cnt, 0);
    endtask

    initial begin
        rst_n   = 1'b0;
        pulse_i = 1'b0;
        t_reset();
        t_idle();
        t_isolated(1, "R4 one-cycle pulse");
        t_isolated(3, "R2 three-cycle pulse");
        t_isolated(7, "R2 seven-cycle pulse");
        t_overlap(3, 1, 2);
        t_overlap(4, 2, 1);
        t_glitch();
        t_saturate(CEIL + 5);
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule